// File: doc/BRIEF.md
# Full-Duplex PCM/ADPCM Serial Data Port

This block moves one voice channel of companded PCM or ADPCM codes between a system-clocked datapath and an external serial bus. The two directions are independent. Each has its own bit clock and its own 8 kHz frame sync. Transmit data changes on rising bit-clock edges. Receive data is captured on falling bit-clock edges. Inside the block, each external line passes through a short synchronizer chain. Every edge is then found by oversampling with the system clock, which has to run several times faster than the fastest bit clock.

A 2-bit rate field selects the code length per frame: 8, 4, 3 or 2 bits, for 64, 32, 24 or 16 kbps. The system side hands over transmit codes with a one-cycle load strobe. Received codes come back with a one-cycle valid strobe. Codes sit right-aligned in an 8-bit word and travel MSB first. When a frame begins with no fresh code loaded, the previous code is sent again and an underrun flag is raised. The serial output floats outside its slot. The synchronous active-low power-down/reset input clears both directions.

Top module: `pcm_serial_port`

## Requirements
- R1: `rate` selects the bits per slot as 0→8, 1→4, 2→3 and 3→2. A code occupies bits [n-1:0] of its 8-bit word, and bit n-1 travels first.
- R2: A transmit slot starts at the first rising edge of `tx_bclk` that sees `tx_fsync` high when the previous rising edge saw it low. The code's MSB is driven from that edge, and one further bit is driven per rising edge after it.
- R3: `tx_sd_en` is high, and `tx_sd` is driven, for exactly n bit periods per slot. At all other times `tx_sd_en` is low and `tx_sd` is high impedance.
- R4: When no `tx_load` has arrived since the last slot start, the new slot sends the previously sent word again and sets `tx_underrun`. `tx_underrun` is recomputed at every slot start and is cleared when a fresh word is used.
- R5: A receive slot starts at the first falling edge of `rx_bclk` that sees `rx_fsync` high after a falling edge that saw it low. `rx_sd` is sampled MSB first on that edge and on the next n-1 falling edges. Levels on `rx_sd` outside the slot have no effect.
- R6: One system cycle after the last bit of a slot is sampled, `rx_valid` pulses for exactly one cycle. `rx_code` then holds the code zero-extended to 8 bits.
- R7: The rate is captured at slot start. Changing `rate` during a slot does not change that slot's length, in either direction.
- R8: A frame sync held high for several bit periods starts only one slot.
- R9: While `rst_n` is low, `tx_sd_en`, `tx_underrun` and `rx_valid` are low and the stored transmit word is cleared. A first slot after reset with no load therefore sends zeros with `tx_underrun` set.
- R10: When several `tx_load` strobes arrive before a slot starts, the last one's code is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples both serial sides |
| rst_n | input | 1 | Synchronous active-low power-down/reset |
| rate | input | 2 | Code length select (0:8, 1:4, 2:3, 3:2 bits) |
| tx_code | input | 8 | Transmit code, right-aligned |
| tx_load | input | 1 | One-cycle strobe that accepts `tx_code` |
| tx_underrun | output | 1 | Current slot repeats the previous word |
| tx_bclk | input | 1 | Transmit bit clock |
| tx_fsync | input | 1 | Transmit frame sync |
| tx_sd | output | 1 | Serial transmit data, high impedance outside the slot |
| tx_sd_en | output | 1 | High while `tx_sd` is driven |
| rx_bclk | input | 1 | Receive bit clock |
| rx_fsync | input | 1 | Receive frame sync |
| rx_sd | input | 1 | Serial receive data |
| rx_code | output | 8 | Received code, zero-extended |
| rx_valid | output | 1 | One-cycle strobe for `rx_code` |

## Verification
The bench walks through all four code lengths in both directions and compares slot lengths bit for bit. A design that decoded the rate wrongly or lost count would send too many or too few bits, or leave the output driven after the slot. Frame syncs held high for several bit periods, and rate changes in the middle of a slot, are aimed at designs that restart a slot on a level instead of an edge, or that read the rate continuously. Frames with no load, and frames with two loads, expose a wrong repeat-or-replace choice or a missing underrun flag. Noise on the receive line between slots catches a receiver that samples outside its window.

// File: rtl/pcm_port_pkg.sv
// Shared definitions for the serial data port: rate encoding and the
// bits-per-slot decode. Assumes the rate field is two bits wide.
package pcm_port_pkg;

    localparam int RATE_W = 2;

    typedef enum logic [RATE_W-1:0] {
        RATE_64K = 2'd0,
        RATE_32K = 2'd1,
        RATE_24K = 2'd2,
        RATE_16K = 2'd3
    } rate_e;

    // Number of serial bits carried per frame for a rate setting (R1).
    function automatic int slot_bits(input logic [RATE_W-1:0] rate);
        case (rate_e'(rate))
            RATE_64K: slot_bits = 8;
            RATE_32K: slot_bits = 4;
            RATE_24K: slot_bits = 3;
            default:  slot_bits = 2;
        endcase
    endfunction

endpackage

// File: rtl/pcm_edge_sync.sv
// Multi-stage synchronizer for a vector of asynchronous serial-side lines.
// Assumes every bit of the vector is sampled by the same chain, so that
// data and clock lines keep their relative timing after synchronization.
module pcm_edge_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the raw lines through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/pcm_tx_path.sv
// Transmit side: holds the next code, starts a slot on the first rising
// bit-clock edge that sees frame sync newly high, and shifts the code out
// MSB first, one bit per rising edge. Assumes synchronized inputs and a
// system clock several times faster than the bit clock.
module pcm_tx_path
    import pcm_port_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              load_i,
    input  logic              bclk_i,
    input  logic              fsync_i,
    output logic              sd_o,
    output logic              sd_en_o,
    output logic              underrun_o
);

    localparam int IDX_W = $clog2(CODE_W);

    logic              bclk_prev_q;
    logic              fs_prev_q;
    logic [CODE_W-1:0] hold_q;
    logic              pend_q;
    logic [CODE_W-1:0] word_q;
    logic [CNT_W-1:0]  nbits_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              en_q;
    logic              bit_q;
    logic              under_q;

    logic              bclk_rise;
    logic              slot_start;
    logic [CODE_W-1:0] next_word;
    logic [CNT_W-1:0]  start_bits;
    logic [IDX_W-1:0]  start_idx;
    logic [IDX_W-1:0]  shift_idx;

    assign bclk_rise  = bclk_i & ~bclk_prev_q;
    assign slot_start = bclk_rise & fsync_i & ~fs_prev_q;
    assign next_word  = pend_q ? hold_q : word_q;
    assign start_bits = CNT_W'(slot_bits(rate_i));
    assign start_idx  = IDX_W'(start_bits - CNT_W'(1));
    assign shift_idx  = IDX_W'(nbits_q - CNT_W'(1) - cnt_q);

    // Track bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_prev_q <= 1'b0;
        else        bclk_prev_q <= bclk_i;
    end

    // Remember the frame sync level seen at the previous rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         fs_prev_q <= 1'b0;
        else if (bclk_rise) fs_prev_q <= fsync_i;
    end

    // Holding register: the latest loaded code wins (R10).
    always_ff @(posedge clk) begin
        if (!rst_n)      hold_q <= '0;
        else if (load_i) hold_q <= code_i;
    end

    // Pending flag: set by a load, consumed by a slot start.
    always_ff @(posedge clk) begin
        if (!rst_n)          pend_q <= 1'b0;
        else if (load_i)     pend_q <= 1'b1;
        else if (slot_start) pend_q <= 1'b0;
    end

    // Slot engine: capture the word and rate, then drive one bit per rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q  <= '0;
            nbits_q <= '0;
            cnt_q   <= '0;
            en_q    <= 1'b0;
            bit_q   <= 1'b0;
            under_q <= 1'b0;
        end else if (slot_start) begin
            word_q  <= next_word;
            nbits_q <= start_bits;
            cnt_q   <= CNT_W'(1);
            en_q    <= 1'b1;
            bit_q   <= next_word[start_idx];
            under_q <= ~pend_q;
        end else if (bclk_rise && en_q) begin
            if (cnt_q < nbits_q) begin
                bit_q <= word_q[shift_idx];
                cnt_q <= cnt_q + CNT_W'(1);
            end else begin
                en_q  <= 1'b0;
                cnt_q <= '0;
            end
        end
    end

    assign sd_o       = bit_q;
    assign sd_en_o    = en_q;
    assign underrun_o = under_q;

    // R3: the driver is only enabled inside a counted slot.
    a_r3_en_window: assert property (@(posedge clk) disable iff (!rst_n)
        en_q |-> (cnt_q >= CNT_W'(1) && cnt_q <= nbits_q));

    // R2: the output bit only changes on a rising bit-clock edge.
    a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_rise |=> $stable(bit_q) && $stable(en_q));

    // R4: the underrun flag only moves at a slot boundary.
    a_r4_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bclk_rise |=> $stable(under_q));

    // R7: the captured length stays fixed while a slot is running.
    a_r7_len_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q && !bclk_rise) |=> $stable(nbits_q));

endmodule

// File: rtl/pcm_rx_path.sv
// Receive side: starts a slot on the first falling bit-clock edge that sees
// frame sync newly high, samples the data line MSB first on each falling
// edge and issues a one-cycle valid with the zero-extended code. Assumes
// data and bit clock come through the same synchronizer chain.
module pcm_rx_path
    import pcm_port_pkg::*;
#(
    parameter int CODE_W = 8,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              bclk_i,
    input  logic              fsync_i,
    input  logic              sd_i,
    output logic [CODE_W-1:0] code_o,
    output logic              valid_o
);

    logic              bclk_prev_q;
    logic              fs_prev_q;
    logic [CODE_W-1:0] shift_q;
    logic [CNT_W-1:0]  nbits_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              busy_q;
    logic [CODE_W-1:0] code_q;
    logic              valid_q;

    logic              bclk_fall;
    logic              slot_start;
    logic [CODE_W-1:0] shift_next;

    assign bclk_fall  = ~bclk_i & bclk_prev_q;
    assign slot_start = bclk_fall & fsync_i & ~fs_prev_q;
    assign shift_next = {shift_q[CODE_W-2:0], sd_i};

    // Track bit-clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) bclk_prev_q <= 1'b0;
        else        bclk_prev_q <= bclk_i;
    end

    // Remember the frame sync level seen at the previous falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n)         fs_prev_q <= 1'b0;
        else if (bclk_fall) fs_prev_q <= fsync_i;
    end

    // Slot engine: sample the first bit at start, then one per falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shift_q <= '0;
            nbits_q <= '0;
            cnt_q   <= '0;
            busy_q  <= 1'b0;
            code_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (slot_start) begin
                shift_q <= CODE_W'(sd_i);
                nbits_q <= CNT_W'(slot_bits(rate_i));
                cnt_q   <= CNT_W'(1);
                busy_q  <= 1'b1;
            end else if (bclk_fall && busy_q) begin
                shift_q <= shift_next;
                cnt_q   <= cnt_q + CNT_W'(1);
                if (cnt_q + CNT_W'(1) == nbits_q) begin
                    busy_q  <= 1'b0;
                    code_q  <= shift_next;
                    valid_q <= 1'b1;
                end
            end
        end
    end

    assign code_o  = code_q;
    assign valid_o = valid_q;

    // R6: a delivered code is a single-cycle pulse.
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q);

    // R5: a code is only completed by a falling bit-clock edge.
    a_r5_after_fall: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> $past(bclk_fall));

    // R6: bits above the slot length are zero.
    a_r6_zero_ext: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |-> ((code_q >> nbits_q) == '0));

endmodule

// File: rtl/pcm_serial_port.sv
// Top of the full-duplex serial data port. Synchronizes both serial sides
// into the system clock domain and joins the transmit and receive paths.
// Assumes clk runs at least about eight times the fastest bit clock.
module pcm_serial_port
    import pcm_port_pkg::*;
#(
    parameter int CODE_W    = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        rate,
    input  logic [CODE_W-1:0] tx_code,
    input  logic              tx_load,
    output logic              tx_underrun,
    input  logic              tx_bclk,
    input  logic              tx_fsync,
    output logic              tx_sd,
    output logic              tx_sd_en,
    input  logic              rx_bclk,
    input  logic              rx_fsync,
    input  logic              rx_sd,
    output logic [CODE_W-1:0] rx_code,
    output logic              rx_valid
);

    localparam int CNT_W  = $clog2(CODE_W + 1);
    localparam int LINE_N = 5;

    logic [LINE_N-1:0] raw_lines;
    logic [LINE_N-1:0] sync_lines;
    logic              tx_bit;

    assign raw_lines = {rx_sd, rx_fsync, rx_bclk, tx_fsync, tx_bclk};

    pcm_edge_sync #(
        .WIDTH  (LINE_N),
        .STAGES (SYNC_STGS)
    ) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_lines),
        .sync_o  (sync_lines)
    );

    pcm_tx_path #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) tx_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_i     (rate),
        .code_i     (tx_code),
        .load_i     (tx_load),
        .bclk_i     (sync_lines[0]),
        .fsync_i    (sync_lines[1]),
        .sd_o       (tx_bit),
        .sd_en_o    (tx_sd_en),
        .underrun_o (tx_underrun)
    );

    pcm_rx_path #(
        .CODE_W (CODE_W),
        .CNT_W  (CNT_W)
    ) rx_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .rate_i  (rate),
        .bclk_i  (sync_lines[2]),
        .fsync_i (sync_lines[3]),
        .sd_i    (sync_lines[4]),
        .code_o  (rx_code),
        .valid_o (rx_valid)
    );

    // Float the serial output outside the active slot (R3).
    assign tx_sd = tx_sd_en ? tx_bit : 1'bz;

endmodule

// File: tb/pcm_serial_port_tb.sv
// Scoreboard bench: driver tasks push expected codes into queues; monitors
// pop and compare as serial slots finish or received codes are strobed.
module pcm_serial_port_tb_top;

    typedef struct {
        logic [7:0] code;
        int         nbits;
        logic       under;
    } tx_exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] rate = 2'd0;
    logic [7:0] tx_code = '0;
    logic       tx_load = 1'b0;
    logic       tx_underrun;
    logic       tx_bclk = 1'b0;
    logic       tx_fsync = 1'b0;
    wire        tx_sd;
    logic       tx_sd_en;
    logic       rx_bclk = 1'b0;
    logic       rx_fsync = 1'b0;
    logic       rx_sd = 1'b0;
    logic [7:0] rx_code;
    logic       rx_valid;

    int checks = 0;
    int fails  = 0;
    tx_exp_t    tx_q[$];
    logic [7:0] rx_q[$];
    logic [7:0] last_word = '0;
    logic       pending = 1'b0;

    pcm_serial_port dut_i (
        .clk(clk), .rst_n(rst_n), .rate(rate), .tx_code(tx_code),
        .tx_load(tx_load), .tx_underrun(tx_underrun), .tx_bclk(tx_bclk),
        .tx_fsync(tx_fsync), .tx_sd(tx_sd), .tx_sd_en(tx_sd_en),
        .rx_bclk(rx_bclk), .rx_fsync(rx_fsync), .rx_sd(rx_sd),
        .rx_code(rx_code), .rx_valid(rx_valid)
    );

    always #10 clk = ~clk;
    initial begin #3; forever #400 tx_bclk = ~tx_bclk; end
    initial begin #7; forever #320 rx_bclk = ~rx_bclk; end

    function automatic int nb_of(input logic [1:0] r);
        return (r == 2'd0) ? 8 : (r == 2'd1) ? 4 : (r == 2'd2) ? 3 : 2;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Present one code on the load strobe.
    task automatic tx_push(input logic [7:0] c);
        @(negedge clk);
        tx_code = c;
        tx_load = 1'b1;
        @(negedge clk);
        tx_load = 1'b0;
        last_word = c;
        pending = 1'b1;
    endtask

    // Drive one transmit frame and record its expected slot.
    task automatic tx_frame(input logic [1:0] r, input int hold, input int mid);
        tx_exp_t e;
        @(negedge clk);
        rate = r;
        e.nbits = nb_of(r);
        e.code  = last_word & 8'((1 << e.nbits) - 1);
        e.under = !pending;
        pending = 1'b0;
        tx_q.push_back(e);
        @(negedge tx_bclk);
        tx_fsync = 1'b1;
        for (int i = 1; i <= 12; i++) begin
            @(negedge tx_bclk);
            if (i == hold) tx_fsync = 1'b0;
            if (i == 2 && mid >= 0) rate = 2'(mid);
        end
    endtask

    // Drive one receive frame with noise after the slot.
    task automatic rx_frame(input logic [7:0] c, input logic [1:0] r,
                            input int hold, input int mid);
        int n;
        @(negedge clk);
        rate = r;
        n = nb_of(r);
        rx_q.push_back(c & 8'((1 << n) - 1));
        @(posedge rx_bclk);
        rx_fsync = 1'b1;
        rx_sd = c[n-1];
        for (int i = 1; i <= 11; i++) begin
            @(posedge rx_bclk);
            if (i == hold) rx_fsync = 1'b0;
            if (i < n) rx_sd = c[n-1-i];
            else       rx_sd = ~rx_sd;
            if (i == 2 && mid >= 0) rate = 2'(mid);
        end
    endtask

    // Transmit monitor: collect bits at falling edges, score each finished slot.
    logic [7:0] tx_acc = '0;
    int         tx_cnt = 0;
    always @(negedge tx_bclk) begin
        if (rst_n) begin
            if (tx_sd_en) begin
                tx_acc = {tx_acc[6:0], tx_sd};
                tx_cnt++;
            end else if (tx_cnt > 0) begin
                if (tx_q.size() == 0) begin
                    chk(1'b0, "R2", "unexpected tx slot", tx_acc, 0);
                end else begin
                    tx_exp_t e;
                    e = tx_q.pop_front();
                    chk(tx_cnt == e.nbits, "R1/R3/R7/R8", "tx slot length", tx_cnt, e.nbits);
                    chk(tx_acc == e.code, "R2/R10", "tx code", tx_acc, e.code);
                    chk(tx_underrun == e.under, "R4", "tx underrun", tx_underrun, e.under);
                    chk(tx_sd === 1'bz, "R3", "tx_sd floats after slot", tx_sd, 0);
                end
                tx_cnt = 0;
                tx_acc = '0;
            end
        end
    end

    // Receive monitor: score each valid strobe against the queue.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (rx_q.size() == 0) begin
                chk(1'b0, "R6", "extra rx_valid", rx_code, 0);
            end else begin
                logic [7:0] x;
                x = rx_q.pop_front();
                chk(rx_code == x, "R5/R6", "rx code", rx_code, x);
            end
        end
    end

    initial begin
        #2_000_000;
        fails++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (10) @(negedge clk);
        // R9: outputs held quiet in reset.
        chk(tx_sd_en == 1'b0, "R9", "tx_sd_en in reset", tx_sd_en, 0);
        chk(tx_sd === 1'bz, "R9", "tx_sd in reset", tx_sd, 0);
        chk(tx_underrun == 1'b0, "R9", "underrun in reset", tx_underrun, 0);
        chk(rx_valid == 1'b0, "R9", "rx_valid in reset", rx_valid, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        tx_frame(2'd0, 1, -1);          // R9: zeros with underrun after reset
        tx_push(8'hA5);
        tx_frame(2'd0, 1, -1);          // R1, R2
        tx_push(8'h3C);
        tx_push(8'h96);
        tx_frame(2'd1, 1, -1);          // R10: last load wins
        tx_frame(2'd1, 1, -1);          // R4: repeat with underrun
        tx_push(8'h05);
        tx_frame(2'd2, 3, -1);          // R8: long frame sync
        tx_push(8'h02);
        tx_frame(2'd3, 1, -1);          // R1: shortest slot
        tx_push(8'h81);
        tx_frame(2'd0, 1, 3);           // R7: mid-slot rate change

        rx_frame(8'h5A, 2'd0, 1, -1);   // R5, R6
        rx_frame(8'h09, 2'd1, 1, -1);
        rx_frame(8'hF6, 2'd2, 1, -1);   // R6: upper bits dropped
        rx_frame(8'h01, 2'd3, 1, -1);
        rx_frame(8'hC3, 2'd0, 2, 3);    // R7, R8

        repeat (200) @(negedge clk);
        chk(tx_q.size() == 0, "R3", "tx slots outstanding", tx_q.size(), 0);
        chk(rx_q.size() == 0, "R6", "rx codes outstanding", rx_q.size(), 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule